// File: doc/BRIEF.md
# Width-Selectable Word Serializer

This block turns parallel words into a continuous serial bit stream. It runs entirely on the bit clock. A parallel word is taken from a valid/ready input, and the block then shifts it out one bit per clock cycle. A static mode pin chooses between a narrow 10-bit word and a wide 20-bit word. The mode decides which input lanes are used and which lane leaves first.

The same bit stream drives two serial outputs: a line output toward the medium and a loopback output for diagnostics. Each output has its own active-low enable, and a disabled output is held low. Between words the block leaves no idle cycles as long as the source keeps offering data. A rising edge on the mode pin clears the block's internal state.

Back-pressure rules:
- `in_ready` is high while the block is idle (after reset, after an underrun, or after a mode-pin clear). While a word is streaming, it is high only in the cycle that shows the last bit of that word.
- A word transfers on a clock edge where `in_valid` and `in_ready` are both high.
- While `in_ready` is low, `in_valid` and `in_data` have no effect.

Top module: `word_serializer`

## Requirements
- R1: After reset the block is idle with `in_ready` high, and a word presented with `in_valid` high is accepted on the next rising clock edge.
- R2: With `width_sel` high (10-bit mode), only lanes 10..19 of `in_data` are sent, lane 10 first and lane 19 last. Lanes 0..9 have no effect on the outputs.
- R3: With `width_sel` low (20-bit mode), all 20 lanes are sent, lane 0 first and lane 19 last.
- R4: The first bit of an accepted word appears in the cycle after the accepting edge. While a word streams, `in_ready` is high only in the cycle showing its last bit. A word accepted in that cycle follows with no gap cycle.
- R5: If no word is offered in the last-bit cycle, both outputs go low from the next cycle and `in_ready` stays high. A later accepted word starts in the cycle after it is accepted.
- R6: With both enables low, `line_out` and `loop_out` carry identical bits in every cycle.
- R7: When `line_en_n` is high, `line_out` is low; when `loop_en_n` is high, `loop_out` is low. Either enable can be set independently without disturbing the other output.
- R8: From reset until the first word is accepted, both serial outputs are low.
- R9: A rising edge on `width_sel` drops `in_ready` in that cycle and aborts any word in flight: both outputs are low from the next cycle, and `in_ready` is high again.
- R10: While `in_ready` is low, changes on `in_valid` and `in_data` leave the word in flight unchanged. A word held valid through that time is the one sent next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| width_sel | input | 1 | Word width: 0 = 20-bit, 1 = 10-bit; a rising edge clears the block |
| in_data | input | 20 | Parallel word lanes 0..19 |
| in_valid | input | 1 | Source offers a word on `in_data` |
| in_ready | output | 1 | Block takes the offered word on this edge |
| line_en_n | input | 1 | Active-low enable of the line output |
| loop_en_n | input | 1 | Active-low enable of the loopback output |
| line_out | output | 1 | Serial line output, low when disabled or idle |
| loop_out | output | 1 | Serial loopback output, low when disabled or idle |

## Verification
The assertions assume that `width_sel` changes only while the block is idle or as a deliberate rising edge meant to clear it. They also assume a falling edge never arrives mid-word, and that the bit clock is the only clock. The stimulus follows these rules. It lowers the mode pin only after a stream has drained to idle. It raises the pin once while a 20-bit word is in flight, to exercise the clear path. It changes inputs only on the falling clock edge, so every transfer is decided cleanly on the rising edge.

// File: rtl/ser_pkg.sv
package ser_pkg;
  parameter int unsigned SER_WIDE_W   = 20;
  parameter int unsigned SER_NARROW_W = 10;
  parameter int unsigned SER_NUM_OUTS = 2;

  typedef enum logic {
    MODE_WIDE   = 1'b0,
    MODE_NARROW = 1'b1
  } ser_mode_e;
endpackage

// File: rtl/ser_lane_order.sv
module ser_lane_order
  import ser_pkg::*;
#(
  parameter int unsigned WIDE_W   = SER_WIDE_W,
  parameter int unsigned NARROW_W = SER_NARROW_W
) (
  input  ser_mode_e           mode,
  input  logic [WIDE_W-1:0]   lanes,
  output logic [WIDE_W-1:0]   ordered
);
  localparam int unsigned NARROW_BASE = WIDE_W - NARROW_W;

  // ordered[0] is the first bit to leave the block
  for (genvar i = 0; i < WIDE_W; i++) begin : g_pos
    if (i < NARROW_W) begin : g_shared
      assign ordered[i] = (mode == MODE_NARROW) ? lanes[NARROW_BASE + i] : lanes[i];
    end else begin : g_wide_only
      assign ordered[i] = (mode == MODE_NARROW) ? 1'b0 : lanes[i];
    end
  end
endmodule

// File: rtl/ser_bit_counter.sv
module ser_bit_counter
  import ser_pkg::*;
#(
  parameter int unsigned WIDE_W   = SER_WIDE_W,
  parameter int unsigned NARROW_W = SER_NARROW_W
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      load,
  input  logic      run,
  input  ser_mode_e mode,
  output logic      at_last
);
  localparam int unsigned CNT_W = $clog2(WIDE_W);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE_W - 1);
  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = (mode == MODE_NARROW) ? NARROW_LAST : WIDE_LAST;
  assign at_last  = run && (cnt_q == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
    end else if (run && !at_last) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last_idx));

  // R4
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (cnt_q == '0));
endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic         at_last,
  input  logic [W-1:0] word,
  output logic         active,
  output logic         ser_bit
);
  logic [W-1:0] sr_q;
  logic         active_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      active_q <= 1'b0;
    end else if (load) begin
      active_q <= 1'b1;
    end else if (at_last) begin
      active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= word;
    end else begin
      sr_q <= {1'b0, sr_q[W-1:1]};
    end
  end

  assign active  = active_q;
  assign ser_bit = active_q & sr_q[0];

  // R5
  drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && !load) |=> !active_q);
endmodule

// File: rtl/ser_out_gate.sv
module ser_out_gate #(
  parameter int unsigned N = 2
) (
  input  logic         ser_bit,
  input  logic [N-1:0] en_n,
  output logic [N-1:0] outs
);
  for (genvar k = 0; k < N; k++) begin : g_out
    assign outs[k] = ser_bit & ~en_n[k];
  end
endmodule

// File: rtl/word_serializer.sv
module word_serializer
  import ser_pkg::*;
#(
  parameter int unsigned WIDE_W   = SER_WIDE_W,
  parameter int unsigned NARROW_W = SER_NARROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              width_sel,
  input  logic [WIDE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              line_en_n,
  input  logic              loop_en_n,
  output logic              line_out,
  output logic              loop_out
);
  localparam int unsigned NOUT = SER_NUM_OUTS;

  ser_mode_e         mode;
  logic              width_q;
  logic              clr;
  logic              load;
  logic              active;
  logic              at_last;
  logic              ser_bit;
  logic [WIDE_W-1:0] ordered;
  logic [NOUT-1:0]   outs;

  assign mode = width_sel ? MODE_NARROW : MODE_WIDE;

  always_ff @(posedge clk) begin
    if (!rst_n) width_q <= width_sel;
    else        width_q <= width_sel;
  end

  assign clr      = width_sel & ~width_q;
  assign in_ready = ~clr & (~active | at_last);
  assign load     = in_valid & in_ready;

  ser_lane_order #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_order (
    .mode    (mode),
    .lanes   (in_data),
    .ordered (ordered)
  );

  ser_bit_counter #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .load    (load),
    .run     (active),
    .mode    (mode),
    .at_last (at_last)
  );

  ser_shift_reg #(.W(WIDE_W)) u_sr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .load    (load),
    .at_last (at_last),
    .word    (ordered),
    .active  (active),
    .ser_bit (ser_bit)
  );

  ser_out_gate #(.N(NOUT)) u_gate (
    .ser_bit (ser_bit),
    .en_n    ({loop_en_n, line_en_n}),
    .outs    (outs)
  );

  assign line_out = outs[0];
  assign loop_out = outs[1];

  // R6
  copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_en_n && !loop_en_n) |-> (line_out == loop_out));

  // R7
  line_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_en_n |-> !line_out);

  // R7
  loop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en_n |-> !loop_out);

  // R9
  width_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(width_sel) |-> !in_ready);

  // R9
  width_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(width_sel) && !in_valid) |=> (!line_out && !loop_out && in_ready));

  // R5
  underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (!line_out && !loop_out));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

// File: tb/word_serializer_tb.sv
module word_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        width_sel = 1'b0;
  logic [19:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        line_en_n = 1'b0;
  logic        loop_en_n = 1'b0;
  logic        line_out;
  logic        loop_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5ns clk = ~clk;

  word_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .line_en_n(line_en_n),
    .loop_en_n(loop_en_n), .line_out(line_out), .loop_out(loop_out)
  );

  task automatic chk(input bit ok, input string req, input logic [19:0] act,
                     input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] mkword(input int seed, input int k);
    logic [31:0] v;
    v = seed * 32'h0003_A5C7 + k * 32'h0001_F0B3;
    return v[19:0] ^ 20'h5A5A5;
  endfunction

  // bit i of the result is the i-th serial bit expected
  function automatic logic [19:0] exp_bits(input logic [19:0] w, input logic w10);
    logic [19:0] r;
    r = '0;
    for (int i = 0; i < 20; i++) begin
      if (w10) r[i] = (i < 10) ? w[10 + i] : 1'b0;
      else     r[i] = w[i];
    end
    return r;
  endfunction

  // Sends nw words back to back from idle; checks bits, ready and the drain to idle.
  task automatic xfer(input logic w10, input int nw, input int seed, input bit early,
                      input string tag);
    int          len;
    logic [19:0] w, got_l, got_b, e;
    len = w10 ? 10 : 20;
    @(negedge clk);
    w = mkword(seed, 0);
    in_data  = w;
    in_valid = 1'b1;
    chk(in_ready === 1'b1, {"R1 ready at idle ", tag}, {19'd0, in_ready}, 20'd1);
    for (int k = 0; k < nw; k++) begin
      got_l = '0;
      got_b = '0;
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        got_l[i] = line_out;
        got_b[i] = loop_out;
        if (i == 0) begin
          if (early && (k + 1 < nw)) begin
            in_data = mkword(seed, k + 1);
          end else begin
            in_valid = 1'b0;
            in_data  = ~w;
          end
        end
        if (i == 1)
          chk(in_ready === 1'b0, {"R10 busy mid-word ", tag}, {19'd0, in_ready}, 20'd0);
        if (i == len - 1) begin
          chk(in_ready === 1'b1, {"R4 ready on last bit ", tag}, {19'd0, in_ready}, 20'd1);
          if (k + 1 < nw) begin
            in_data  = mkword(seed, k + 1);
            in_valid = 1'b1;
          end else begin
            in_valid = 1'b0;
          end
        end
      end
      e = exp_bits(w, w10);
      chk(got_l === (line_en_n ? 20'd0 : e),
          {w10 ? "R2 " : "R3 ", "R7 line bits ", tag}, got_l, line_en_n ? 20'd0 : e);
      chk(got_b === (loop_en_n ? 20'd0 : e),
          {w10 ? "R2 " : "R3 ", "R6 R7 loop bits ", tag}, got_b, loop_en_n ? 20'd0 : e);
      w = mkword(seed, k + 1);
    end
    @(negedge clk);
    chk({line_out, loop_out} === 2'b00, {"R5 low after drain ", tag},
        {18'd0, line_out, loop_out}, 20'd0);
    chk(in_ready === 1'b1, {"R5 ready after drain ", tag}, {19'd0, in_ready}, 20'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({line_out, loop_out} === 2'b00, "R8 outputs low after reset",
          {18'd0, line_out, loop_out}, 20'd0);
    end
    chk(in_ready === 1'b1, "R1 ready after reset", {19'd0, in_ready}, 20'd1);
  endtask

  task automatic t_wide();
    xfer(1'b0, 3, 7, 1'b0, "wide stream");
    xfer(1'b0, 2, 11, 1'b1, "wide early valid");
  endtask

  task automatic t_width_rise();
    @(negedge clk);
    in_data  = 20'hFFFFF;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    width_sel = 1'b1;
    #0.1ns;
    chk(in_ready === 1'b0, "R9 ready low on rising mode edge", {19'd0, in_ready}, 20'd0);
    @(negedge clk);
    chk({line_out, loop_out} === 2'b00, "R9 word aborted",
        {18'd0, line_out, loop_out}, 20'd0);
    chk(in_ready === 1'b1, "R9 ready after clear", {19'd0, in_ready}, 20'd1);
  endtask

  task automatic t_narrow();
    xfer(1'b1, 3, 23, 1'b0, "narrow stream");
    xfer(1'b1, 2, 31, 1'b1, "narrow early valid");
  endtask

  task automatic t_enables();
    line_en_n = 1'b1;
    xfer(1'b1, 2, 41, 1'b0, "line disabled");
    line_en_n = 1'b0;
    loop_en_n = 1'b1;
    xfer(1'b1, 2, 43, 1'b0, "loop disabled");
    loop_en_n = 1'b0;
  endtask

  task automatic t_underrun_wide();
    @(negedge clk);
    width_sel = 1'b0;
    @(negedge clk);
    xfer(1'b0, 1, 53, 1'b0, "wide single");
    repeat (3) @(negedge clk);
    chk({line_out, loop_out} === 2'b00, "R5 idle stays low",
        {18'd0, line_out, loop_out}, 20'd0);
    xfer(1'b0, 2, 59, 1'b0, "wide restart");
  endtask

  initial begin
    t_reset();
    t_wide();
    t_width_rise();
    t_narrow();
    t_enables();
    t_underrun_wide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule